// File: doc/BRIEF.md
# Element and Subvector Step Sequencer

This block walks the element positions of one vector operation. A run is opened by a start pulse that captures the vector length (0 to 127 elements) and the subvector length (1 to 4 parts per element). The block then walks every element/part pair once on the source side and once on the destination side. Each position is given as an element index and a part index.

Each side has a flag that picks the loop order on that side. With the flag clear, the part index is the inner (fast) loop. With it set, the element index is the inner loop. The source flag and the destination flag are independent, so the two sides may walk the same positions in different orders.

In the normal mode a free-running advance enable moves the walk one position per cycle. In hold mode the walk moves only on an explicit step pulse. When the last position is consumed, a one-cycle done pulse marks the end of the run.

Top module: `elem_step_seq`

## Requirements
- R1: While reset is held and after it, all four step outputs are zero and `pos_valid` and `seq_done` are low until a start is accepted.
- R2: A start seen while `pos_valid` is low captures `vec_len`, `sub_len`, `src_elem_inner`, `dst_elem_inner` and `hold_mode`. In the next cycle `pos_valid` is high with all step outputs zero, provided `vec_len` is not zero.
- R3: On the source side, with `src_elem_inner` = 0 the part index runs innermost: (e,0),(e,1)..(e,SUBVL-1), then e+1. With it = 1 the element index runs innermost: (0,s)..(VL-1,s), then s+1.
- R4: The destination side follows the same two orders, selected by `dst_elem_inner` alone, whatever the source flag is.
- R5: In normal mode (`hold_mode` = 0 at start), one position is consumed per cycle in which `adv_en` is high. The outputs hold while `adv_en` is low. `step_pulse` has no effect.
- R6: In hold mode (`hold_mode` = 1 at start), only a cycle with `step_pulse` high consumes a position, exactly one per pulse. `adv_en` has no effect.
- R7: The cycle after the final position is consumed, `seq_done` is high for exactly one cycle, `pos_valid` is low and all step outputs are zero.
- R8: A start accepted with `vec_len` = 0 yields no valid position. `seq_done` is high in the next cycle.
- R9: While `pos_valid` is high, `start` and the length and mode inputs are ignored. The running walk continues unchanged.
- R10: While `pos_valid` is high, element indices stay below the captured length and part indices below the captured subvector length. `sub_len` is the plain count 1..4 on three bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a run when idle |
| vec_len | input | 7 | Element count, sampled at start |
| sub_len | input | 3 | Parts per element, 1 to 4, sampled at start |
| src_elem_inner | input | 1 | Source side: element index is the inner loop |
| dst_elem_inner | input | 1 | Destination side: element index is the inner loop |
| hold_mode | input | 1 | Advance only on step_pulse |
| step_pulse | input | 1 | One-position step request in hold mode |
| adv_en | input | 1 | Advance enable in normal mode |
| src_elem | output | 7 | Source element index |
| src_sub | output | 2 | Source part index |
| dst_elem | output | 7 | Destination element index |
| dst_sub | output | 2 | Destination part index |
| pos_valid | output | 1 | A position is being presented |
| seq_done | output | 1 | One-cycle end-of-run pulse |

## Verification
The range and hold properties assume that `sub_len` is only ever 1 to 4 when a start is accepted. A value of zero or above four has no defined walk. The stimulus only offers subvector lengths in that range.

The properties also assume that length and mode inputs matter only at an accepted start. The stimulus deliberately scrambles them after each start, and raises a second start in mid-run, to show they are not re-read. In each mode the ignored advance input is toggled during stalls, so that a hold which wrongly follows it would show up as a skipped position.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
    parameter int ELEM_W = 7;
    parameter int SUB_W  = 2;
    localparam int SUBCNT_W = SUB_W + 1;

    typedef logic [ELEM_W-1:0]   elem_t;
    typedef logic [SUB_W-1:0]    sub_t;
    typedef logic [SUBCNT_W-1:0] subcnt_t;

    // captured run configuration and run state
    typedef struct packed {
        logic    busy;
        logic    done;
        logic    hold;
        logic    src_inv;
        logic    dst_inv;
        elem_t   vl;
        subcnt_t subvl;
    } ctrl_t;

    // one side's position in the walk
    typedef struct packed {
        elem_t elem;
        sub_t  sub;
    } pos_t;
endpackage

// File: rtl/step_walker.sv
module step_walker
    import step_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    adv,
    input  logic    elem_inner,
    input  elem_t   vl,
    input  subcnt_t subvl,
    output pos_t    pos,
    output logic    at_end
);
    pos_t pos_d, pos_q;
    logic elem_last, sub_last;

    always_comb begin
        elem_last = (pos_q.elem == vl - elem_t'(1));
        sub_last  = ({1'b0, pos_q.sub} == subvl - subcnt_t'(1));
        at_end    = elem_last && sub_last;
        pos_d     = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (adv) begin
            if (elem_inner) begin
                // element index is the fast loop
                if (elem_last) begin
                    pos_d.elem = '0;
                    pos_d.sub  = sub_last ? '0 : pos_q.sub + sub_t'(1);
                end else begin
                    pos_d.elem = pos_q.elem + elem_t'(1);
                end
            end else begin
                // part index is the fast loop
                if (sub_last) begin
                    pos_d.sub  = '0;
                    pos_d.elem = elem_last ? '0 : pos_q.elem + elem_t'(1);
                end else begin
                    pos_d.sub = pos_q.sub + sub_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import step_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  elem_t   vl_in,
    input  subcnt_t subvl_in,
    input  logic    src_inv_in,
    input  logic    dst_inv_in,
    input  logic    hold_in,
    input  logic    step_pulse,
    input  logic    adv_en,
    input  logic    last,
    output ctrl_t   cfg,
    output logic    adv,
    output logic    clear
);
    ctrl_t ctrl_d, ctrl_q;
    logic  accept;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        accept      = start && !ctrl_q.busy;
        adv         = ctrl_q.busy && (ctrl_q.hold ? step_pulse : adv_en);
        clear       = accept;
        if (accept) begin
            ctrl_d.vl      = vl_in;
            ctrl_d.subvl   = subvl_in;
            ctrl_d.src_inv = src_inv_in;
            ctrl_d.dst_inv = dst_inv_in;
            ctrl_d.hold    = hold_in;
            if (vl_in == '0) begin
                ctrl_d.busy = 1'b0;
                ctrl_d.done = 1'b1;
            end else begin
                ctrl_d.busy = 1'b1;
            end
        end else if (adv && last) begin
            ctrl_d.busy = 1'b0;
            ctrl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign cfg = ctrl_q;
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
    import step_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ELEM_W-1:0]   vec_len,
    input  logic [SUBCNT_W-1:0] sub_len,
    input  logic                src_elem_inner,
    input  logic                dst_elem_inner,
    input  logic                hold_mode,
    input  logic                step_pulse,
    input  logic                adv_en,
    output logic [ELEM_W-1:0]   src_elem,
    output logic [SUB_W-1:0]    src_sub,
    output logic [ELEM_W-1:0]   dst_elem,
    output logic [SUB_W-1:0]    dst_sub,
    output logic                pos_valid,
    output logic                seq_done
);
    localparam int SIDES = 2;

    ctrl_t cfg;
    logic  adv, clear;
    pos_t  pos    [SIDES];
    logic  at_end [SIDES];

    step_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vl_in      (vec_len),
        .subvl_in   (sub_len),
        .src_inv_in (src_elem_inner),
        .dst_inv_in (dst_elem_inner),
        .hold_in    (hold_mode),
        .step_pulse (step_pulse),
        .adv_en     (adv_en),
        .last       (at_end[0] && at_end[1]),
        .cfg        (cfg),
        .adv        (adv),
        .clear      (clear)
    );

    // side 0 = source, side 1 = destination
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        step_walker u_walk (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear),
            .adv        (adv),
            .elem_inner ((s == 0) ? cfg.src_inv : cfg.dst_inv),
            .vl         (cfg.vl),
            .subvl      (cfg.subvl),
            .pos        (pos[s]),
            .at_end     (at_end[s])
        );
    end

    assign src_elem  = pos[0].elem;
    assign src_sub   = pos[0].sub;
    assign dst_elem  = pos[1].elem;
    assign dst_sub   = pos[1].sub;
    assign pos_valid = cfg.busy;
    assign seq_done  = cfg.done;
endmodule

// File: rtl/elem_step_seq_chk.sv
module elem_step_seq_chk
    import step_seq_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    start,
    input elem_t   vec_len,
    input logic    step_pulse,
    input logic    adv_en,
    input elem_t   src_elem,
    input sub_t    src_sub,
    input elem_t   dst_elem,
    input sub_t    dst_sub,
    input logic    pos_valid,
    input logic    seq_done,
    input elem_t   cap_vl,
    input subcnt_t cap_subvl,
    input logic    cap_hold
);
    assert_step_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |-> (src_elem < cap_vl) && (dst_elem < cap_vl)
                   && ({1'b0, src_sub} < cap_subvl) && ({1'b0, dst_sub} < cap_subvl));

    assert_first_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pos_valid && vec_len != '0) |=> pos_valid && src_elem == '0
            && src_sub == '0 && dst_elem == '0 && dst_sub == '0);

    assert_normal_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && !cap_hold && !adv_en) |=> pos_valid && $stable(src_elem)
            && $stable(src_sub) && $stable(dst_elem) && $stable(dst_sub));

    assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && cap_hold && !step_pulse) |=> pos_valid && $stable(src_elem)
            && $stable(src_sub) && $stable(dst_elem) && $stable(dst_sub));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !pos_valid && src_elem == '0 && src_sub == '0
            && dst_elem == '0 && dst_sub == '0);

    assert_empty_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pos_valid && vec_len == '0) |=> seq_done && !pos_valid);
endmodule

bind elem_step_seq elem_step_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vec_len    (vec_len),
    .step_pulse (step_pulse),
    .adv_en     (adv_en),
    .src_elem   (src_elem),
    .src_sub    (src_sub),
    .dst_elem   (dst_elem),
    .dst_sub    (dst_sub),
    .pos_valid  (pos_valid),
    .seq_done   (seq_done),
    .cap_vl     (cfg.vl),
    .cap_subvl  (cfg.subvl),
    .cap_hold   (cfg.hold)
);

// File: tb/elem_step_seq_bench.sv
`timescale 1ns/1ps
module elem_step_seq_bench;
    import step_seq_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, src_in = 0, dst_in = 0, hold = 0, stp = 0, adv = 0;
    logic [ELEM_W-1:0]   vl_i = '0;
    logic [SUBCNT_W-1:0] sv_i = 3'd1;
    logic [ELEM_W-1:0]   src_e, dst_e;
    logic [SUB_W-1:0]    src_s, dst_s;
    logic valid, done;

    always #2 clk = ~clk;

    elem_step_seq u_elem_step_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vl_i), .sub_len(sv_i),
        .src_elem_inner(src_in), .dst_elem_inner(dst_in), .hold_mode(hold),
        .step_pulse(stp), .adv_en(adv), .src_elem(src_e), .src_sub(src_s),
        .dst_elem(dst_e), .dst_sub(dst_s), .pos_valid(valid), .seq_done(done)
    );

    typedef struct { int se; int ss; int de; int ds; bit fin; } exp_t;
    exp_t  sbq[$];
    int    checks = 0, fails = 0;
    string tag = "R1";
    bit    mode_hold = 0;
    bit    ending = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: compares presented positions against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !ending && (valid || done)) begin
            if (sbq.size() == 0) begin
                chk(0, tag, "output with empty scoreboard", 1, 0);
            end else begin
                exp_t e;
                e = sbq[0];
                if (done) begin
                    chk(e.fin && !valid, "R7", "done pulse at end", {valid, e.fin}, 1);
                    chk({src_e, src_s, dst_e, dst_s} == 0, "R7", "steps zero at done",
                        int'({src_e, src_s, dst_e, dst_s}), 0);
                    void'(sbq.pop_front());
                end else begin
                    chk(!e.fin, tag, "valid where done expected", 1, 0);
                    chk(int'(src_e) == e.se && int'(src_s) == e.ss, tag, "source elem*4+sub",
                        int'(src_e) * 4 + int'(src_s), e.se * 4 + e.ss);
                    chk(int'(dst_e) == e.de && int'(dst_s) == e.ds, tag, "dest elem*4+sub",
                        int'(dst_e) * 4 + int'(dst_s), e.de * 4 + e.ds);
                    if (mode_hold ? stp : adv) void'(sbq.pop_front());
                end
            end
        end
    end

    task automatic run(int vl, int sv, bit pk, bit up, bit hm, int stall_every,
                       bit poke, string t);
        int sq[$];
        int dq[$];
        if (!pk) begin
            for (int e = 0; e < vl; e++) for (int s = 0; s < sv; s++) sq.push_back(e * 4 + s);
        end else begin
            for (int s = 0; s < sv; s++) for (int e = 0; e < vl; e++) sq.push_back(e * 4 + s);
        end
        if (!up) begin
            for (int e = 0; e < vl; e++) for (int s = 0; s < sv; s++) dq.push_back(e * 4 + s);
        end else begin
            for (int s = 0; s < sv; s++) for (int e = 0; e < vl; e++) dq.push_back(e * 4 + s);
        end
        for (int i = 0; i < sq.size(); i++)
            sbq.push_back('{sq[i] / 4, sq[i] % 4, dq[i] / 4, dq[i] % 4, 1'b0});
        sbq.push_back('{0, 0, 0, 0, 1'b1});
        tag = t;
        mode_hold = hm;
        @(posedge clk); #1;
        vl_i = ELEM_W'(vl); sv_i = SUBCNT_W'(sv); src_in = pk; dst_in = up; hold = hm;
        start = 1; adv = 0; stp = 0;
        @(posedge clk); #1;
        start = 0;
        // scrambled after capture: must not matter (R9)
        vl_i = 7'd5; sv_i = 3'd3; src_in = ~pk; dst_in = ~up; hold = ~hm;
        for (int i = 0; i < vl * sv; i++) begin
            if (stall_every > 0 && (i % stall_every) == 1) begin
                adv = hm; stp = !hm;   // only the ignored input is high
                @(posedge clk); #1;
            end
            adv = !hm; stp = hm;
            if (poke && i == 2) start = 1;
            @(posedge clk); #1;
            start = 0;
        end
        adv = 0; stp = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(sbq.size() == 0, t, "scoreboard drained", sbq.size(), 0);
        sbq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        ending = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk({valid, done, src_e, src_s, dst_e, dst_s} == 0, "R1", "outputs in reset",
            int'({valid, done, src_e, src_s, dst_e, dst_s}), 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk({valid, done} == 0, "R1", "idle after reset", int'({valid, done}), 0);

        run(3, 2, 0, 0, 0, 0, 0, "R2_R3_R5");
        run(3, 3, 1, 0, 0, 3, 0, "R3_R5");
        run(2, 4, 0, 1, 0, 0, 0, "R4");
        run(4, 2, 1, 1, 0, 2, 1, "R9");
        run(3, 2, 1, 0, 1, 2, 0, "R6");
        run(5, 1, 0, 1, 1, 3, 0, "R6_R4");
        run(0, 2, 0, 0, 0, 0, 0, "R8");
        run(1, 1, 0, 0, 0, 0, 0, "R10");
        run(127, 4, 0, 1, 0, 0, 0, "R10");

        ending = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule